// File: doc/BRIEF.md
# Software Store/Recall Command Detector

This block watches the accesses that a host makes to a static RAM and picks out a fixed chain of six read addresses. When it sees the complete chain, it issues either a save command or a restore command to the controller of a nonvolatile backing array. A save command is also raised by a hardware request pin, or by the rising edge of a power-low warning. The backing array itself is not part of this block.

The block keeps a flag that records whether any SRAM write has been accepted since the last save. A save request is dropped when that flag is clear, so an unchanged array is never copied again. While the controller works, the block locks the host out of the RAM. A write that is already held when power comes up, or when a command ends, stays blocked until the host releases write mode.

The bus is sampled on every rising clock edge. Any clock with chip enable low counts as one access.

Top module: `sw_nv_cmd_detect`

## Requirements
- R1: The reset state is as follows: both command strobes low, `busLock` low, the sequence tracker at its first step, the written flag clear and write inhibit armed. A clock with `ceN` high is idle and leaves the tracker unchanged.
- R2: Only `addr[13:0]` takes part in the address comparison, and `addr[14]` is ignored. The five shared addresses, in order, are 0x1A5C, 0x25A3, 0x0F0F, 0x30F0 and 0x1C3E. The sixth address is 0x2B71 for a save or 0x0D4E for a restore. A read is a clock with `ceN`=0 and `weN`=1.
- R3: A save chain whose sixth read arrives while the written flag is set raises `storeStb` for exactly one clock, in the clock after that read.
- R4: A restore chain raises `recallStb` for exactly one clock, in the clock after the sixth read. The two strobes are never high together.
- R5: The tracker goes back to its first step on any of these: a read whose address does not match the expected step (that read does not count as step one), any write cycle (`ceN`=0 and `weN`=0), or a completed chain.
- R6: A save request from any source is dropped while the written flag is clear, and no strobe follows.
- R7: `busLock` rises together with a command strobe. It stays high until the first clock after `busy` has been seen high and then low. While it is high, `sramRdEn` and `sramWrEn` are low, reads do not move the tracker, and new requests are ignored.
- R8: `sramRdEn` is high when `ceN`=0, `weN`=1, `oeN`=0 and `busLock` is low.
- R9: `sramWrEn` is high in write mode when the block is neither locked nor inhibited. Inhibit is armed at reset and at the end of every command. It clears on the first clock that is not in write mode.
- R10: A low level on `hwStoreN`, or a rising edge of `powerLow`, requests a save while the block is idle. A save request wins over a restore chain that completes in the same clock.
- R11: The written flag sets on each accepted write. It clears only when a save command completes, so a restore leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, treated as power-up |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | 15 | Host address |
| busy | input | 1 | Nonvolatile controller is working |
| hwStoreN | input | 1 | Hardware save request, active low |
| powerLow | input | 1 | Supply falling warning |
| storeStb | output | 1 | One-clock save command |
| recallStb | output | 1 | One-clock restore command |
| busLock | output | 1 | Host locked out of the RAM |
| sramRdEn | output | 1 | Read enable passed on to the RAM |
| sramWrEn | output | 1 | Write enable passed on to the RAM |

## Verification
A wrong tracker step shows up only at the sixth read of a chain. The result is a strobe that is missing, or one that appears after a broken chain, one clock after that read. So the stimulus mixes partial chains, bad addresses and writes placed at every step. A wrong written flag or a wrong inhibit bit stays hidden until the next save request, or the next write held over a command's end. For that reason the bench compares every strobe, `busLock` and both enables on every clock against a cycle model, including the clocks in which nothing is expected to happen.

// File: rtl/sr_cmd_pkg.sv
package sr_cmd_pkg;
  // Length of the command chain (five shared reads plus the selecting read)
  localparam int SEQ_LEN = 6;
  localparam int STEP_W  = $clog2(SEQ_LEN + 1);

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_WAIT,
    OP_RUN
  } opState_t;

  // Strobes from the control into the datapath
  typedef struct packed {
    logic clearDirty;
    logic armInhibit;
  } ctlStb_t;
endpackage

// File: rtl/sr_cmd_datapath.sv
module sr_cmd_datapath
  import sr_cmd_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int CMP_W  = 14,
  parameter logic [CMP_W-1:0] SEQ_0 = 14'h1A5C,
  parameter logic [CMP_W-1:0] SEQ_1 = 14'h25A3,
  parameter logic [CMP_W-1:0] SEQ_2 = 14'h0F0F,
  parameter logic [CMP_W-1:0] SEQ_3 = 14'h30F0,
  parameter logic [CMP_W-1:0] SEQ_4 = 14'h1C3E,
  parameter logic [CMP_W-1:0] SEQ_STORE  = 14'h2B71,
  parameter logic [CMP_W-1:0] SEQ_RECALL = 14'h0D4E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              powerLow,
  input  logic              busLock,
  input  ctlStb_t           stb,
  output logic              rdAcc,
  output logic              wrCycle,
  output logic [SEQ_LEN-2:0] matchVec,
  output logic              matchStore,
  output logic              matchRecall,
  output logic              dirty,
  output logic              pwrEdge,
  output logic              sramWrEn,
  output logic              sramRdEn
);
  localparam int SHARED = SEQ_LEN - 1;
  localparam logic [SHARED-1:0][CMP_W-1:0] SEQ_TAB = {SEQ_4, SEQ_3, SEQ_2, SEQ_1, SEQ_0};

  logic [CMP_W-1:0] cmpAddr;
  logic wrMode;
  logic wrInhibit;
  logic pwrPrev;

  assign cmpAddr = addr[CMP_W-1:0];

  generate
    if (ADDR_W > CMP_W) begin : g_hi
      logic unusedAddrHi;
      assign unusedAddrHi = ^addr[ADDR_W-1:CMP_W];
    end
  endgenerate

  // One comparator per shared step
  generate
    for (genvar i = 0; i < SHARED; i++) begin : g_cmp
      assign matchVec[i] = (cmpAddr == SEQ_TAB[i]);
    end
  endgenerate

  assign matchStore  = (cmpAddr == SEQ_STORE);
  assign matchRecall = (cmpAddr == SEQ_RECALL);

  assign wrMode   = !ceN && !weN;
  assign wrCycle  = wrMode;
  assign rdAcc    = !ceN && weN && !busLock;
  assign sramRdEn = !ceN && weN && !oeN && !busLock;
  assign sramWrEn = wrMode && !wrInhibit && !busLock;
  assign pwrEdge  = powerLow && !pwrPrev;

  // Write inhibit: armed at power-up and at command end, released out of write mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               wrInhibit <= 1'b1;
    else if (stb.armInhibit) wrInhibit <= 1'b1;
    else if (!wrMode)        wrInhibit <= 1'b0;
  end

  // Written-since-save flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dirty <= 1'b0;
    else if (stb.clearDirty) dirty <= 1'b0;
    else if (sramWrEn)       dirty <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwrPrev <= 1'b0;
    else       pwrPrev <= powerLow;
  end
endmodule

// File: rtl/sr_cmd_ctrl.sv
module sr_cmd_ctrl
  import sr_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdAcc,
  input  logic               wrCycle,
  input  logic [SEQ_LEN-2:0] matchVec,
  input  logic               matchStore,
  input  logic               matchRecall,
  input  logic               dirty,
  input  logic               pwrEdge,
  input  logic               hwStoreN,
  input  logic               busy,
  output logic               storeStb,
  output logic               recallStb,
  output logic               busLock,
  output ctlStb_t            stb
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

  opState_t opState;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] stepNext;
  logic [(1<<STEP_W)-1:0] hitVec;
  logic opIsStore;
  logic idle, seqLast, seqStore, seqRecall, storeWant;
  logic startStore, startRecall, opDone;

  assign idle      = (opState == OP_IDLE);
  assign seqLast   = idle && rdAcc && (step == LAST_STEP);
  assign seqStore  = seqLast && matchStore;
  assign seqRecall = seqLast && matchRecall;
  assign storeWant = seqStore || !hwStoreN || pwrEdge;

  // Save sources take priority; a save with nothing written is dropped
  assign startStore  = idle && storeWant && dirty;
  assign startRecall = idle && seqRecall && !startStore;
  assign opDone      = (opState == OP_RUN) && !busy;

  assign busLock        = !idle;
  assign stb.clearDirty = opDone && opIsStore;
  assign stb.armInhibit = opDone;

  always_comb begin
    hitVec = '0;
    hitVec[SEQ_LEN-2:0] = matchVec;
  end

  always_comb begin
    stepNext = step;
    if (idle) begin
      if (wrCycle)                 stepNext = '0;
      else if (rdAcc) begin
        if (step == LAST_STEP)     stepNext = '0;
        else if (hitVec[step])     stepNext = step + 1'b1;
        else                       stepNext = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) step <= '0;
    else       step <= stepNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opState   <= OP_IDLE;
      opIsStore <= 1'b0;
    end else begin
      case (opState)
        OP_IDLE: begin
          if (startStore || startRecall) begin
            opState   <= OP_WAIT;
            opIsStore <= startStore;
          end
        end
        OP_WAIT: if (busy) opState <= OP_RUN;
        OP_RUN:  if (!busy) opState <= OP_IDLE;
        default: opState <= OP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeStb  <= 1'b0;
      recallStb <= 1'b0;
    end else begin
      storeStb  <= startStore;
      recallStb <= startRecall;
    end
  end
endmodule

// File: rtl/sw_nv_cmd_detect.sv
module sw_nv_cmd_detect
  import sr_cmd_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int CMP_W  = 14,
  parameter logic [CMP_W-1:0] SEQ_0 = 14'h1A5C,
  parameter logic [CMP_W-1:0] SEQ_1 = 14'h25A3,
  parameter logic [CMP_W-1:0] SEQ_2 = 14'h0F0F,
  parameter logic [CMP_W-1:0] SEQ_3 = 14'h30F0,
  parameter logic [CMP_W-1:0] SEQ_4 = 14'h1C3E,
  parameter logic [CMP_W-1:0] SEQ_STORE  = 14'h2B71,
  parameter logic [CMP_W-1:0] SEQ_RECALL = 14'h0D4E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  input  logic              hwStoreN,
  input  logic              powerLow,
  output logic              storeStb,
  output logic              recallStb,
  output logic              busLock,
  output logic              sramRdEn,
  output logic              sramWrEn
);
  ctlStb_t stb;
  logic rdAcc, wrCycle, matchStore, matchRecall, dirty, pwrEdge;
  logic [SEQ_LEN-2:0] matchVec;

  sr_cmd_datapath #(
    .ADDR_W(ADDR_W), .CMP_W(CMP_W),
    .SEQ_0(SEQ_0), .SEQ_1(SEQ_1), .SEQ_2(SEQ_2), .SEQ_3(SEQ_3), .SEQ_4(SEQ_4),
    .SEQ_STORE(SEQ_STORE), .SEQ_RECALL(SEQ_RECALL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .powerLow(powerLow), .busLock(busLock), .stb(stb),
    .rdAcc(rdAcc), .wrCycle(wrCycle), .matchVec(matchVec),
    .matchStore(matchStore), .matchRecall(matchRecall), .dirty(dirty),
    .pwrEdge(pwrEdge), .sramWrEn(sramWrEn), .sramRdEn(sramRdEn)
  );

  sr_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdAcc(rdAcc), .wrCycle(wrCycle),
    .matchVec(matchVec), .matchStore(matchStore), .matchRecall(matchRecall),
    .dirty(dirty), .pwrEdge(pwrEdge), .hwStoreN(hwStoreN), .busy(busy),
    .storeStb(storeStb), .recallStb(recallStb), .busLock(busLock), .stb(stb)
  );
endmodule

// File: rtl/sw_nv_cmd_detect_chk.sv
module sw_nv_cmd_detect_chk (
  input logic clk,
  input logic rstN,
  input logic ceN,
  input logic weN,
  input logic busy,
  input logic storeStb,
  input logic recallStb,
  input logic busLock,
  input logic sramWrEn
);
  // R3
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeStb |=> !storeStb);

  // R4
  recall_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallStb |=> !recallStb);

  // R4
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(storeStb && recallStb));

  // R7
  lock_on_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (storeStb || recallStb) |-> (busLock && !$past(busLock)));

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busLock && busy) |=> busLock);

  // R7
  lock_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busLock) |-> !$past(busy));

  // R9
  inhibit_after_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busLock) && !ceN && !weN) |-> !sramWrEn);
endmodule

bind sw_nv_cmd_detect sw_nv_cmd_detect_chk u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .busy(busy),
  .storeStb(storeStb), .recallStb(recallStb), .busLock(busLock),
  .sramWrEn(sramWrEn)
);

// File: tb/test_sw_nv_cmd_detect.sv
module test_sw_nv_cmd_detect;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 15;
  localparam int BUSY_LEN   = 3;
  localparam logic [13:0] A0 = 14'h1A5C, A1 = 14'h25A3, A2 = 14'h0F0F,
                          A3 = 14'h30F0, A4 = 14'h1C3E,
                          A_ST = 14'h2B71, A_RC = 14'h0D4E;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b0, weN = 1'b0, oeN = 1'b1, busy = 1'b0, hwStoreN = 1'b1, powerLow = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic storeStb, recallStb, busLock, sramRdEn, sramWrEn;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_nv_cmd_detect i_sw_nv_cmd_detect (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .busy(busy), .hwStoreN(hwStoreN), .powerLow(powerLow),
    .storeStb(storeStb), .recallStb(recallStb), .busLock(busLock),
    .sramRdEn(sramRdEn), .sramWrEn(sramWrEn)
  );

  int errors = 0, checks = 0, busyCnt = 0, nStore = 0, nRecall = 0;
  bit finished = 0;
  // cycle model state
  int mStep = 0, mOp = 0;
  bit mDirty = 0, mInh = 1, mKind = 0, mPwrPrev = 0, mStoreStb = 0, mRecallStb = 0;

  function automatic logic [13:0] seqAt(input int idx);
    case (idx)
      0: return A0;
      1: return A1;
      2: return A2;
      3: return A3;
      default: return A4;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chkInt(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Model of one clock edge, using the inputs of the cycle before it
  task automatic modelEdge();
    bit lockPre, wrMode, rd, accWr, pEdge, last, sRec, sSt, want, startS, startR, done;
    lockPre = (mOp != 0);
    wrMode  = !ceN && !weN;
    rd      = !ceN && weN && !lockPre;
    accWr   = wrMode && !mInh && !lockPre;
    pEdge   = powerLow && !mPwrPrev;
    last    = (mOp == 0) && rd && (mStep == 5);
    sSt     = last && (addr[13:0] == A_ST);
    sRec    = last && (addr[13:0] == A_RC);
    want    = sSt || !hwStoreN || pEdge;
    startS  = (mOp == 0) && want && mDirty;
    startR  = (mOp == 0) && sRec && !startS;
    done    = (mOp == 2) && !busy;
    if (mOp == 0) begin
      if (wrMode) mStep = 0;
      else if (rd) begin
        if (mStep == 5) mStep = 0;
        else if (addr[13:0] == seqAt(mStep)) mStep++;
        else mStep = 0;
      end
    end
    if (done && mKind) mDirty = 0;
    else if (accWr) mDirty = 1;
    if (done) mInh = 1;
    else if (!wrMode) mInh = 0;
    if (startS) begin mOp = 1; mKind = 1; end
    else if (startR) begin mOp = 1; mKind = 0; end
    else if (mOp == 1 && busy) mOp = 2;
    else if (done) mOp = 0;
    mPwrPrev   = powerLow;
    mStoreStb  = startS;
    mRecallStb = startR;
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic cyc(input logic c, input logic w, input logic o, input logic [ADDR_W-1:0] a);
    bit lockNow;
    ceN = c; weN = w; oeN = o; addr = a;
    busy = (busyCnt > 0);
    if (busyCnt > 0) busyCnt--;
    #1;
    lockNow = (mOp != 0);
    chk("R9", "sramWrEn", sramWrEn, !c && !w && !mInh && !lockNow);
    chk("R8", "sramRdEn", sramRdEn, !c && w && !o && !lockNow);
    @(posedge clk);
    modelEdge();
    #1;
    chk("R3", "storeStb", storeStb, mStoreStb);
    chk("R4", "recallStb", recallStb, mRecallStb);
    chk("R7", "busLock", busLock, mOp != 0);
    if (storeStb) nStore++;
    if (recallStb) nRecall++;
    if (mStoreStb || mRecallStb) busyCnt = BUSY_LEN;
    @(negedge clk);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a); cyc(1'b0, 1'b1, 1'b0, a); endtask
  task automatic wr(input logic [ADDR_W-1:0] a); cyc(1'b0, 1'b0, 1'b1, a); endtask
  task automatic idleCyc(); cyc(1'b1, 1'b1, 1'b1, '0); endtask

  task automatic runSeq(input logic [13:0] lastA, input logic hi);
    for (int i = 0; i < 5; i++) rd({hi, seqAt(i)});
    rd({hi, lastA});
  endtask

  task automatic waitOp();
    for (int i = 0; i < 20 && (mOp != 0 || busyCnt != 0); i++) idleCyc();
    idleCyc();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  initial begin
    int s0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "storeStb after reset", storeStb, 1'b0);
    chk("R1", "recallStb after reset", recallStb, 1'b0);
    chk("R1", "busLock after reset", busLock, 1'b0);
    // R9 write held through power-up is blocked
    chk("R9", "power-up held write", sramWrEn, 1'b0);
    wr(15'h0001);
    wr(15'h0002);
    rd(15'h0003);
    wr(15'h0004);           // accepted, sets written flag (R11)
    // R4 restore chain
    s0 = nRecall;
    runSeq(A_RC, 1'b0);
    idleCyc();
    chkInt("R4", "restore strobes", nRecall, s0 + 1);
    waitOp();
    // R11 flag survives a restore
    s0 = nStore;
    runSeq(A_ST, 1'b0);
    idleCyc();
    chkInt("R11", "save after restore", nStore, s0 + 1);
    waitOp();
    // R6 save with nothing written is dropped
    s0 = nStore;
    runSeq(A_ST, 1'b0);
    idleCyc();
    chkInt("R6", "dropped save", nStore, s0);
    s0 = nRecall;
    runSeq(A_RC, 1'b0);
    idleCyc();
    chkInt("R6", "tracker restarted after dropped save", nRecall, s0 + 1);
    waitOp();
    // R5 mismatch and write inside a chain
    idleCyc();
    wr(15'h0100);
    s0 = nStore;
    rd({1'b0, A0}); rd({1'b0, A1}); rd({1'b0, A2}); rd(15'h0000);
    rd({1'b0, A3}); rd({1'b0, A4}); rd({1'b0, A_ST});
    rd({1'b0, A0}); rd({1'b0, A1}); wr(15'h0101); idleCyc();
    rd({1'b0, A2}); rd({1'b0, A3}); rd({1'b0, A4}); rd({1'b0, A_ST});
    idleCyc();
    chkInt("R5", "broken chains give no save", nStore, s0);
    // R2 upper address bit ignored, R1 idle clocks hold the tracker
    rd({1'b1, A0}); idleCyc(); rd({1'b1, A1}); idleCyc(); idleCyc();
    rd({1'b1, A2}); rd({1'b0, A3}); idleCyc(); rd({1'b1, A4}); rd({1'b1, A_ST});
    idleCyc();
    chkInt("R2", "save with bit 14 set and idle gaps (R1)", nStore, s0 + 1);
    waitOp();
    // R10 hardware pin
    idleCyc(); wr(15'h0200);
    s0 = nStore;
    hwStoreN = 1'b0; idleCyc(); hwStoreN = 1'b1; idleCyc();
    chkInt("R10", "pin save", nStore, s0 + 1);
    waitOp();
    hwStoreN = 1'b0; idleCyc(); hwStoreN = 1'b1; idleCyc();
    chkInt("R10", "pin save without writes", nStore, s0 + 1);
    // R10 power-low edge
    wr(15'h0201);
    powerLow = 1'b1; idleCyc(); idleCyc();
    chkInt("R10", "power-low save", nStore, s0 + 2);
    waitOp();
    wr(15'h0202); idleCyc(); idleCyc();
    chkInt("R10", "level of powerLow gives no second save", nStore, s0 + 2);
    powerLow = 1'b0; idleCyc();
    // R7 reads during lockout are ignored
    s0 = nStore;
    runSeq(A_RC, 1'b0);
    runSeq(A_ST, 1'b0);
    idleCyc();
    chkInt("R7", "chain during lockout", nStore, s0);
    waitOp();
    // R9 write held across the end of a command
    wr(15'h0300); idleCyc();
    runSeq(A_ST, 1'b0);
    for (int i = 0; i < 8; i++) wr(15'h0301);
    idleCyc(); wr(15'h0302);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [13:0] a;
      r = $urandom_range(0, 99);
      hwStoreN = ($urandom_range(0, 99) != 0);
      if ($urandom_range(0, 199) == 0) powerLow = !powerLow;
      if (r < 60) begin
        if (mStep == 5) a = ($urandom_range(0, 1) != 0) ? A_ST : A_RC;
        else a = seqAt(mStep);
        if ($urandom_range(0, 9) == 0) a = 14'($urandom());
        cyc(1'b0, 1'b1, 1'($urandom_range(0, 1)), {1'($urandom_range(0, 1)), a});
      end else if (r < 75) begin
        wr(15'($urandom()));
      end else if (r < 88) begin
        idleCyc();
      end else begin
        rd(15'($urandom()));
      end
    end
    hwStoreN = 1'b1;
    waitOp();
    summary();
  end
endmodule